// File: doc/BRIEF.md
# Selectable-Latency Synchronous RAM Port

This block is a single access port on a synchronous static RAM. Every rising clock edge it captures an address, a write word, a read/write strobe and a pair of chip-select inputs, one active low and one active high. A selected edge with the strobe low stores the word. A selected edge with the strobe high starts a read. On-chip tristates are not used, so the read side is a data vector plus a drive flag that says when the data is valid and would be driving the bus.

A static latency input sets the read timing. When it is low, read data shows after the same edge that captured the address. When it is high, one more register stage sits on the output path. The chip-select state goes through that extra stage too, so selection and deselection each take two edges to reach the outputs. An asynchronous release input cuts the drive at once, with no clock involved. The array is inferred from the address and data widths. The full part is `AW = 15` and `DW = 9`, which gives 32K x 9. The default is `AW = 11` so that elaboration stays light.

Top module: `sync_ram_port`

## Requirements
- R1: The port counts as selected only when `sel_n` is 0 and `sel_p` is 1 at a rising edge. Every other combination stores nothing, and the edge's output slot is not driven (`rdrive` = 0).
- R2: A selected edge with `wr_n` = 0 stores `wdata` at `addr`. A later selected read of that address returns the stored word.
- R3: With `latency_sel` = 0, a selected read (`wr_n` = 1) drives `rdrive` = 1 and the word at `addr` right after the edge that captured it.
- R4: With `latency_sel` = 1, the same read result appears one rising edge later than under R3.
- R5: With `latency_sel` = 1, a deselected edge releases the outputs only after the next edge, which makes two edges in all. With `latency_sel` = 0 it takes one edge.
- R6: `drive_off` = 1 forces `rdrive` to 0 at once, with no clock edge. Releasing it brings back the pending read result, again with no clock edge.
- R7: A write edge never drives the outputs. Its slot shows `rdrive` = 0, delayed by one extra edge when `latency_sel` = 1.
- R8: Whenever `rdrive` is 0, `rdata` reads all zeros.
- R9: Repeated selected reads of one address, with no write in between, keep returning the same word with `rdrive` held at 1.
- R10: While `rst_n` is 0 at a rising edge, the output stages are flushed. `rdrive` is 0 after that edge in either latency mode, even if read commands are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, flushes the output stages |
| latency_sel | input | 1 | 0: read data after the capturing edge; 1: one edge later |
| drive_off | input | 1 | Asynchronous output release, active high |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| wr_n | input | 1 | 0 = write, 1 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write word |
| rdata | output | DW | Read word, zero when not driven |
| rdrive | output | 1 | Output valid / bus drive flag |

## Verification
Every command the driver applies has its result due at a fixed edge. In latency mode 0 that is the edge that captures the command. In mode 1 it is the following edge. The driver tags each expected item with that edge's number, and the monitor compares an item only in the cycle whose edge number matches, sampling one nanosecond after the edge. The mode is switched only after idle, deselected cycles, so that results due under the two latencies never fall in the same slot. The asynchronous release is checked between two edges, with no clock edge between the stimulus and the sample.

// File: rtl/sram_port_pkg.sv
// Package: types shared by the RAM port pieces.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_port_pkg;

    // Control recorded for one captured edge: was the port selected, was it a read
    typedef struct packed {
        logic sel;
        logic rd;
    } ctl_t;

endpackage

// File: rtl/spr_capture.sv
// Input capture stage: registers select and direction state and the address on
// each rising edge, and produces the write strobe for the array.
// Assumes: synchronous active-low reset; the write lands on the capturing edge.
module spr_capture
    import sram_port_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output ctl_t          cap_ctl,
    output logic [AW-1:0] cap_addr,
    output logic          wr_strobe
);

    logic sel_now;

    // Decode the two chip selects into one select term
    assign sel_now   = !sel_n && sel_p;
    // Write only on a selected edge with the strobe low, never in reset
    assign wr_strobe = rst_n && sel_now && !wr_n;

    // First control/address register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ctl  <= '0;
            cap_addr <= '0;
        end else begin
            cap_ctl.sel <= sel_now;
            cap_ctl.rd  <= wr_n;
            cap_addr    <= addr;
        end
    end

endmodule

// File: rtl/spr_array.sv
// Storage array: one synchronous write port, asynchronous read of a registered
// address.
// Assumes: the depth is 2**AW and the contents are not reset.
module spr_array #(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the word on a write edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read the word at the captured address
    assign rdata = mem[raddr];

endmodule

// File: rtl/spr_outstage.sv
// Output stage: optional second register on both data and control, a latency
// select, and the asynchronous release of the drive.
// Assumes: latency_sel is static, or changed only while the port is deselected.
module spr_outstage
    import sram_port_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latency_sel,
    input  logic          drive_off,
    input  ctl_t          stg1_ctl,
    input  logic [DW-1:0] stg1_data,
    output logic [DW-1:0] rdata,
    output logic          rdrive
);

    ctl_t          stg2_ctl;
    logic [DW-1:0] stg2_data;
    ctl_t          act_ctl;
    logic [DW-1:0] act_data;

    // Second stage: delays data and selects by one more edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg2_ctl  <= '0;
            stg2_data <= '0;
        end else begin
            stg2_ctl  <= stg1_ctl;
            stg2_data <= stg1_data;
        end
    end

    // Pick the stage that matches the chosen latency
    always_comb begin
        if (latency_sel) begin
            act_ctl  = stg2_ctl;
            act_data = stg2_data;
        end else begin
            act_ctl  = stg1_ctl;
            act_data = stg1_data;
        end
    end

    // Drive only for a selected read, and only while not released
    assign rdrive = act_ctl.sel && act_ctl.rd && !drive_off;
    assign rdata  = rdrive ? act_data : '0;

endmodule

// File: rtl/sync_ram_port.sv
// Top level: one synchronous RAM port with flow-through or pipelined reads.
// Assumes: single clock, synchronous active-low reset, static latency select.
module sync_ram_port
    import sram_port_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latency_sel,
    input  logic          drive_off,
    input  logic          sel_n,
    input  logic          sel_p,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdrive
);

    ctl_t          cap_ctl;
    logic [AW-1:0] cap_addr;
    logic          wr_strobe;
    logic [DW-1:0] arr_rdata;

    spr_capture #(.AW(AW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel_p    (sel_p),
        .wr_n     (wr_n),
        .addr     (addr),
        .cap_ctl  (cap_ctl),
        .cap_addr (cap_addr),
        .wr_strobe(wr_strobe)
    );

    spr_array #(.AW(AW), .DW(DW)) u_arr (
        .clk  (clk),
        .we   (wr_strobe),
        .waddr(addr),
        .wdata(wdata),
        .raddr(cap_addr),
        .rdata(arr_rdata)
    );

    spr_outstage #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .latency_sel(latency_sel),
        .drive_off  (drive_off),
        .stg1_ctl   (cap_ctl),
        .stg1_data  (arr_rdata),
        .rdata      (rdata),
        .rdrive     (rdrive)
    );

endmodule

// File: rtl/sync_ram_port_checker.sv
// Checker: port-level timing properties of the RAM port, bound to the top.
// Assumes: latency_sel changes only while the port is deselected.
module sync_ram_port_checker (
    input logic clk,
    input logic rst_n,
    input logic latency_sel,
    input logic drive_off,
    input logic sel_n,
    input logic sel_p,
    input logic wr_n,
    input logic rdrive
);

    logic sel_in;
    assign sel_in = !sel_n && sel_p;

    // R1
    flow_desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latency_sel && !sel_in) |=> !rdrive);

    // R3
    flow_read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latency_sel && sel_in && wr_n) |=> (rdrive || drive_off));

    // R5
    pipe_desel_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latency_sel && !sel_in) |=> ##1 !rdrive);

    // R7
    flow_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latency_sel && sel_in && !wr_n) |=> !rdrive);

    // R7
    pipe_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latency_sel && sel_in && !wr_n) |=> ##1 !rdrive);

endmodule

bind sync_ram_port sync_ram_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latency_sel(latency_sel),
    .drive_off  (drive_off),
    .sel_n      (sel_n),
    .sel_p      (sel_p),
    .wr_n       (wr_n),
    .rdrive     (rdrive)
);

// File: tb/sync_ram_port_test.sv
`timescale 1ns/100ps
module sync_ram_port_test;

    localparam int AW = 11;
    localparam int DW = 9;
    localparam int TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          latency_sel = 1'b0;
    logic          drive_off = 1'b0;
    logic          sel_n = 1'b1;
    logic          sel_p = 1'b0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdrive;

    typedef struct {
        int          due;
        bit          drv;
        logic [DW-1:0] dat;
        string       req;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] shadow [int];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    sync_ram_port #(.AW(AW), .DW(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .latency_sel(latency_sel),
        .drive_off  (drive_off),
        .sel_n      (sel_n),
        .sel_p      (sel_p),
        .wr_n       (wr_n),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdrive     (rdrive)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: apply one command and queue the result it must produce
    task automatic step(input bit sn, input bit sp, input bit wn,
                        input int a, input int d, input string req);
        exp_t e;
        bit   sel;
        @(negedge clk);
        sel_n = sn; sel_p = sp; wr_n = wn;
        addr = AW'(a); wdata = DW'(d);
        sel   = !sn && sp;
        e.req = req;
        e.due = cyc + (latency_sel ? 2 : 1);
        e.drv = sel && wn;
        e.dat = e.drv ? shadow[a] : '0;
        if (sel && !wn) shadow[a] = DW'(d);
        sb.push_back(e);
    endtask

    // Deselected cycles with no queued result
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel_n = 1'b1; sel_p = 1'b0; wr_n = 1'b1;
        end
    endtask

    // Monitor: compare queued results in the cycle they are due
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(rdrive == e.drv, e.req, "rdrive", int'(rdrive), int'(e.drv));
                // R8: undriven slots read zero
                check(rdata == e.dat, e.drv ? e.req : "R8", "rdata", int'(rdata), int'(e.dat));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R10 actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state in flow mode
        repeat (3) @(negedge clk);
        #5;
        check(rdrive == 1'b0, "R10", "rdrive in reset", int'(rdrive), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R7: writes in flow mode
        step(0, 1, 0, 'h012, 'h1A5, "R7");
        step(0, 1, 0, 'h345, 'h05A, "R7");
        step(0, 1, 0, TOP,   'h1FF, "R7");
        // R3: flow reads
        step(0, 1, 1, 'h012, 0, "R3");
        step(0, 1, 1, 'h345, 0, "R2");
        // R9: same address read again
        step(0, 1, 1, 'h345, 0, "R9");
        step(0, 1, 1, 'h345, 0, "R9");
        step(0, 1, 1, TOP,   0, "R2");

        // R1: the three non-selecting combinations store nothing, drive nothing
        step(1, 1, 0, 'h012, 'h000, "R1");
        step(0, 0, 0, 'h012, 'h0F0, "R1");
        step(1, 0, 1, 'h012, 0, "R1");
        step(0, 1, 1, 'h012, 0, "R1");

        // R6: asynchronous release between edges
        step(0, 1, 1, 'h345, 0, "R6");
        @(posedge clk);
        #2;
        drive_off = 1'b1;
        #0.5;
        check(rdrive == 1'b0, "R6", "rdrive while released", int'(rdrive), 0);
        check(rdata == '0, "R6", "rdata while released", int'(rdata), 0);
        drive_off = 1'b0;
        #0.5;
        check(rdrive == 1'b1, "R6", "rdrive after release", int'(rdrive), 1);
        check(rdata == DW'('h05A), "R6", "rdata after release", int'(rdata), 'h05A);

        // Change latency while deselected
        idle(3);
        latency_sel = 1'b1;
        idle(3);

        // R4: pipelined reads one edge later
        step(0, 1, 1, 'h012, 0, "R4");
        step(0, 1, 1, TOP,   0, "R4");
        // R7: pipelined write leaves its slot undriven
        step(0, 1, 0, 'h0AB, 'h133, "R7");
        step(0, 1, 1, 'h0AB, 0, "R2");
        // R5: deselect releases two edges later, then reselect
        step(1, 0, 1, 'h012, 0, "R5");
        step(1, 1, 1, 'h012, 0, "R5");
        step(0, 1, 1, 'h012, 0, "R5");
        // R9: steady pipelined reads
        step(0, 1, 1, 'h012, 0, "R9");
        step(0, 1, 1, 'h012, 0, "R9");
        step(0, 1, 0, 'h012, 'h0C3, "R7");
        step(0, 1, 1, 'h012, 0, "R2");
        idle(4);

        // R10: reset in pipelined mode flushes both stages despite reads
        @(negedge clk);
        rst_n = 1'b0;
        sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b1; addr = AW'('h012);
        @(posedge clk);
        #1;
        check(rdrive == 1'b0, "R10", "rdrive pipe reset edge 1", int'(rdrive), 0);
        @(posedge clk);
        #1;
        check(rdrive == 1'b0, "R10", "rdrive pipe reset edge 2", int'(rdrive), 0);
        @(negedge clk);
        sel_n = 1'b1; sel_p = 1'b0;
        rst_n = 1'b1;
        step(0, 1, 1, 'h012, 0, "R4");
        idle(4);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule